// File: doc/BRIEF.md
# SPI FIFO Watermark DMA Request Controller

This block sits between the transmit and receive FIFOs of an SPI controller and a system DMA engine. It keeps its own count of the entries in each FIFO, using the occupancy events it sees. From those counts it decides when to ask the DMA engine for a burst. The transmit side asks for a refill once the transmit FIFO has drained down to a programmed data level. The receive side asks for a drain once the receive FIFO holds more entries than its programmed level. The FIFO storage, the serial shifter and the DMA engine are not part of the block. They appear only as single-cycle strobes and as a request/acknowledge pair per direction.

A request is held until the DMA acknowledges it. After the acknowledge the direction waits for a programmed number of beats, and only then can it ask again. The block also records three sticky error conditions: a transmit write into a full FIFO, a serial read from an empty transmit FIFO during an active transfer, and a serial write into a full receive FIFO. In each case the offending operation is dropped. A combinational configuration check warns when the transmit burst length could overfill the FIFO.

No data passes through this block, only occupancy events. For that reason the FIFO-side pins are plain one-cycle strobes and not valid/ready channels. A strobe is never back-pressured. An event that cannot be honoured is dropped and flagged.

Top module: `spi_dma_watermark`

## Requirements
- R1: One cycle after a cycle in which the transmit direction is idle, tx_en is 1 and tx_fill <= tx_thresh, tx_req is 1. tx_req is never raised while tx_fill > tx_thresh.
- R2: One cycle after a cycle in which the receive direction is idle, rx_en is 1 and rx_fill >= rx_thresh + 1, rx_req is 1. rx_req is never raised below that level.
- R3: A request held high falls in the cycle after its acknowledge. It cannot rise again until the burst has seen burst-length beat strobes, each of which is counted whether accepted or dropped. The beat strobe is tx_push for transmit and rx_pop for receive. A burst length of 0 ends the burst after one cycle.
- R4: While a direction's enable is 0, that direction's request is 0 from the next cycle on.
- R5: cfg_err is 1 exactly when tx_burst + tx_thresh > DEPTH, that is, when the burst is larger than the free space at the request level.
- R6: A tx_push while tx_fill == DEPTH with no accepted tx_pop is dropped, leaving the fill unchanged, and sets tx_ovf. With DEPTH 256, tx_thresh 192 and a burst of 64, the burst ends with tx_fill = 256 and tx_ovf = 0.
- R7: A tx_pop while tx_fill == 0 is ignored. It sets tx_unf only if xfer_active is 1.
- R8: An rx_push while rx_fill == DEPTH with no accepted rx_pop is dropped and sets rx_ovf.
- R9: The flags are sticky. Each bit of flag_clr clears one flag (bit 0 tx_ovf, bit 1 tx_unf, bit 2 rx_ovf). When a set and a clear happen in the same cycle, the set wins.
- R10: Synchronous reset clears both fills, both requests, all flags and both burst states.
- R11: Each fill changes one cycle after its strobes: +1 for an accepted push, -1 for an accepted pop. A push into a full FIFO is accepted when a pop is accepted in the same cycle. A single transmit pop during a 64-beat burst started at fill 192 leaves tx_fill at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit request enable |
| rx_en | input | 1 | Receive request enable |
| tx_thresh | input | LW | Transmit data level |
| rx_thresh | input | LW | Receive data level (request at this value + 1) |
| tx_burst | input | LW | Transmit burst length in beats |
| rx_burst | input | LW | Receive burst length in beats |
| xfer_active | input | 1 | Serial transfer in progress |
| tx_push | input | 1 | DMA writes one transmit entry |
| tx_pop | input | 1 | Serial side takes one transmit entry |
| tx_ack | input | 1 | DMA acknowledges transmit request |
| tx_req | output | 1 | Transmit burst request |
| rx_push | input | 1 | Serial side stores one received word |
| rx_pop | input | 1 | DMA reads one receive entry |
| rx_ack | input | 1 | DMA acknowledges receive request |
| rx_req | output | 1 | Receive burst request |
| flag_clr | input | 3 | Write-one-to-clear strobes for the sticky flags |
| tx_fill | output | LW | Transmit FIFO entry count |
| rx_fill | output | LW | Receive FIFO entry count |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_unf | output | 1 | Sticky transmit underflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| cfg_err | output | 1 | Transmit burst exceeds free space at request level |

## Verification
Directed runs cover the exact-full transmit burst at level 192. They tell a burst that fills the FIFO apart from one that overflows it, and a burst with no serial activity apart from one that overlaps a single pop. Directed runs also cover the receive level offset by one, so a request at the register value can be told apart from one at value + 1. Random phases then bias push and pop rates in both directions. One set of phases holds the FIFOs near empty, where underflow and refill requests dominate. The other holds them near full, where dropped writes and drain requests dominate. Random acknowledges, enable toggles and flag clears separate request gating from burst counting.

// File: rtl/spi_dma_wm_pkg.sv
package spi_dma_wm_pkg;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_REQ   = 2'd1,
    HS_BURST = 2'd2
  } hs_state_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_TX_OVF = 0;
  localparam int unsigned FLAG_TX_UNF = 1;
  localparam int unsigned FLAG_RX_OVF = 2;

endpackage

// File: rtl/wm_fill_tracker.sv
module wm_fill_tracker #(
  parameter int DEPTH = 256,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [LW-1:0] fill,
  output logic          push_drop,
  output logic          pop_empty
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic pop_ok;
  logic push_ok;

  // a pop needs an entry; a push needs room, or a pop freeing one
  assign pop_ok    = pop && (fill != '0);
  assign push_ok   = push && ((fill != FULL) || pop_ok);
  assign push_drop = push && !push_ok;
  assign pop_empty = pop && (fill == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   fill <= fill + LW'(1);
        2'b01:   fill <= fill - LW'(1);
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/wm_burst_handshake.sv
module wm_burst_handshake
  import spi_dma_wm_pkg::*;
#(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          thresh_met,
  input  logic          ack,
  input  logic          beat,
  input  logic [LW-1:0] burst_len,
  output logic          req
);

  hs_state_e     st, st_n;
  logic [LW-1:0] beats, beats_n;
  logic [LW-1:0] beats_inc;

  assign beats_inc = beats + LW'(1);

  always_comb begin
    st_n    = st;
    beats_n = beats;
    unique case (st)
      HS_IDLE: begin
        if (enable && thresh_met) st_n = HS_REQ;
      end
      HS_REQ: begin
        if (!enable) begin
          st_n = HS_IDLE;
        end else if (ack) begin
          st_n    = HS_BURST;
          beats_n = '0;
        end
      end
      HS_BURST: begin
        if (burst_len == '0) begin
          st_n = HS_IDLE;
        end else if (beat) begin
          if (beats_inc >= burst_len) st_n = HS_IDLE;
          else                        beats_n = beats_inc;
        end
      end
      default: st_n = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= HS_IDLE;
      beats <= '0;
    end else begin
      st    <= st_n;
      beats <= beats_n;
    end
  end

  assign req = (st == HS_REQ);

endmodule

// File: rtl/wm_sticky_flags.sv
module wm_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_dma_watermark.sv
module spi_dma_watermark
  import spi_dma_wm_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic [LW-1:0] tx_thresh,
  input  logic [LW-1:0] rx_thresh,
  input  logic [LW-1:0] tx_burst,
  input  logic [LW-1:0] rx_burst,
  input  logic          xfer_active,
  input  logic          tx_push,
  input  logic          tx_pop,
  input  logic          tx_ack,
  output logic          tx_req,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          rx_ack,
  output logic          rx_req,
  input  logic [2:0]    flag_clr,
  output logic [LW-1:0] tx_fill,
  output logic [LW-1:0] rx_fill,
  output logic          tx_ovf,
  output logic          tx_unf,
  output logic          rx_ovf,
  output logic          cfg_err
);

  localparam logic [LW:0] DEPTH_X = (LW + 1)'(DEPTH);

  logic tx_drop, tx_empty_pop;
  logic rx_drop, rx_empty_pop;
  logic [NUM_FLAGS-1:0] flag_set, flag_q;

  wm_fill_tracker #(.DEPTH(DEPTH)) u_tx_fill (
    .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
    .fill(tx_fill), .push_drop(tx_drop), .pop_empty(tx_empty_pop)
  );

  wm_fill_tracker #(.DEPTH(DEPTH)) u_rx_fill (
    .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
    .fill(rx_fill), .push_drop(rx_drop), .pop_empty(rx_empty_pop)
  );

  // transmit refills when drained to its level; receive drains above its level
  wm_burst_handshake #(.LW(LW)) u_tx_hs (
    .clk(clk), .rst(rst), .enable(tx_en),
    .thresh_met(tx_fill <= tx_thresh),
    .ack(tx_ack), .beat(tx_push), .burst_len(tx_burst), .req(tx_req)
  );

  wm_burst_handshake #(.LW(LW)) u_rx_hs (
    .clk(clk), .rst(rst), .enable(rx_en),
    .thresh_met(rx_fill > rx_thresh),
    .ack(rx_ack), .beat(rx_pop), .burst_len(rx_burst), .req(rx_req)
  );

  always_comb begin
    flag_set              = '0;
    flag_set[FLAG_TX_OVF] = tx_drop;
    flag_set[FLAG_TX_UNF] = tx_empty_pop && xfer_active;
    flag_set[FLAG_RX_OVF] = rx_drop;
  end

  wm_sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .flags(flag_q)
  );

  assign tx_ovf = flag_q[FLAG_TX_OVF];
  assign tx_unf = flag_q[FLAG_TX_UNF];
  assign rx_ovf = flag_q[FLAG_RX_OVF];

  assign cfg_err = ({1'b0, tx_burst} + {1'b0, tx_thresh}) > DEPTH_X;

endmodule

// File: rtl/spi_dma_watermark_chk.sv
module spi_dma_watermark_chk #(
  parameter int DEPTH = 256,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_en,
  input logic          rx_en,
  input logic [LW-1:0] tx_thresh,
  input logic [LW-1:0] rx_thresh,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          tx_ack,
  input logic          tx_req,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_ack,
  input logic          rx_req,
  input logic [2:0]    flag_clr,
  input logic [LW-1:0] tx_fill,
  input logic [LW-1:0] rx_fill,
  input logic          tx_ovf,
  input logic          rx_ovf
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  // R1
  tx_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> $past(tx_fill <= tx_thresh));

  // R2
  rx_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_req) |-> $past(rx_fill > rx_thresh));

  // R3
  tx_ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req && tx_ack |=> !tx_req);

  // R3
  rx_ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rx_req && rx_ack |=> !rx_req);

  // R4
  tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !tx_req);

  // R4
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !rx_req);

  // R6
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    tx_push && !tx_pop && (tx_fill == FULL) |=> tx_ovf && $stable(tx_fill));

  // R8
  rx_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_push && !rx_pop && (rx_fill == FULL) |=> rx_ovf && $stable(rx_fill));

  // R9
  tx_ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ovf && !flag_clr[0] |=> tx_ovf);

  // R9
  rx_ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ovf && !flag_clr[2] |=> rx_ovf);

  // R11
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_fill <= FULL) && (rx_fill <= FULL));

endmodule

bind spi_dma_watermark spi_dma_watermark_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
  .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_ack(tx_ack), .tx_req(tx_req),
  .rx_push(rx_push), .rx_pop(rx_pop), .rx_ack(rx_ack), .rx_req(rx_req),
  .flag_clr(flag_clr), .tx_fill(tx_fill), .rx_fill(rx_fill),
  .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
);

// File: tb/spi_dma_watermark_bench.sv
module spi_dma_watermark_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst;
  logic tx_en, rx_en, xfer_active;
  logic [LW-1:0] tx_thresh, rx_thresh, tx_burst, rx_burst;
  logic tx_push, tx_pop, tx_ack, rx_push, rx_pop, rx_ack;
  logic [2:0] flag_clr;
  logic tx_req, rx_req, tx_ovf, tx_unf, rx_ovf, cfg_err;
  logic [LW-1:0] tx_fill, rx_fill;

  spi_dma_watermark #(.DEPTH(DEPTH)) u_spi_dma_watermark (
    .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
    .tx_burst(tx_burst), .rx_burst(rx_burst), .xfer_active(xfer_active),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_ack(tx_ack), .tx_req(tx_req),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_ack(rx_ack), .rx_req(rx_req),
    .flag_clr(flag_clr), .tx_fill(tx_fill), .rx_fill(rx_fill),
    .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state: 0 idle, 1 requesting, 2 in burst
  int m_txf, m_rxf, m_txs, m_rxs, m_txb, m_rxb;
  bit m_tovf, m_tunf, m_rovf;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_txf = 0; m_rxf = 0; m_txs = 0; m_rxs = 0; m_txb = 0; m_rxb = 0;
    m_tovf = 0; m_tunf = 0; m_rovf = 0;
  endtask

  task automatic hs_step(inout int st, inout int bt, input bit en,
                         input bit met, input bit ack, input bit beat,
                         input int blen);
    case (st)
      0: if (en && met) st = 1;
      1: if (!en) st = 0;
         else if (ack) begin st = 2; bt = 0; end
      default: begin
        if (blen == 0) st = 0;
        else if (beat) begin
          if (bt + 1 >= blen) st = 0;
          else bt = bt + 1;
        end
      end
    endcase
  endtask

  task automatic model_step();
    bit tpo, tpu, rpo, rpu, tset_o, tset_u, rset_o;
    tpo = tx_pop && (m_txf > 0);
    tpu = tx_push && ((m_txf < DEPTH) || tpo);
    rpo = rx_pop && (m_rxf > 0);
    rpu = rx_push && ((m_rxf < DEPTH) || rpo);
    tset_o = tx_push && !tpu;
    tset_u = tx_pop && (m_txf == 0) && xfer_active;
    rset_o = rx_push && !rpu;
    hs_step(m_txs, m_txb, tx_en, m_txf <= int'(tx_thresh), tx_ack, tx_push,
            int'(tx_burst));
    hs_step(m_rxs, m_rxb, rx_en, m_rxf >= int'(rx_thresh) + 1, rx_ack, rx_pop,
            int'(rx_burst));
    m_txf = m_txf + int'(tpu) - int'(tpo);
    m_rxf = m_rxf + int'(rpu) - int'(rpo);
    m_tovf = tset_o || (m_tovf && !flag_clr[0]);
    m_tunf = tset_u || (m_tunf && !flag_clr[1]);
    m_rovf = rset_o || (m_rovf && !flag_clr[2]);
  endtask

  task automatic compare_all();
    chk("R1 tx_req", int'(tx_req), int'(m_txs == 1));
    chk("R2 rx_req", int'(rx_req), int'(m_rxs == 1));
    chk("R11 tx_fill", int'(tx_fill), m_txf);
    chk("R11 rx_fill", int'(rx_fill), m_rxf);
    chk("R6 tx_ovf", int'(tx_ovf), int'(m_tovf));
    chk("R7 tx_unf", int'(tx_unf), int'(m_tunf));
    chk("R8 rx_ovf", int'(rx_ovf), int'(m_rovf));
    chk("R5 cfg_err", int'(cfg_err),
        int'(int'(tx_burst) + int'(tx_thresh) > DEPTH));
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_strobes();
    tx_push = 0; tx_pop = 0; tx_ack = 0;
    rx_push = 0; rx_pop = 0; rx_ack = 0; flag_clr = 3'b000;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; tx_en = 0; rx_en = 0; xfer_active = 0;
    tx_thresh = 0; rx_thresh = 0; tx_burst = 0; rx_burst = 0;
    idle_strobes();
    repeat (3) @(negedge clk);
    model_reset();
    // R10 reset state
    chk("R10 tx_req", int'(tx_req), 0);
    chk("R10 rx_req", int'(rx_req), 0);
    chk("R10 tx_fill", int'(tx_fill), 0);
    chk("R10 flags", int'({tx_ovf, tx_unf, rx_ovf}), 0);
    rst = 0;

    // exact-full transmit burst: depth 256, level 192, burst 64
    tx_en = 1; tx_thresh = 192; tx_burst = 64;
    tick();
    tx_push = 1; ticks(192); tx_push = 0;
    chk("R1 tx_req held at level", int'(tx_req), 1);
    tx_ack = 1; tick(); tx_ack = 0;
    chk("R3 tx_req drops after ack", int'(tx_req), 0);
    tx_push = 1; ticks(64); tx_push = 0;
    chk("R6 exact full fill", int'(tx_fill), 256);
    chk("R6 exact full no ovf", int'(tx_ovf), 0);
    tick();
    chk("R1 no req above level", int'(tx_req), 0);
    tx_push = 1; tick(); tx_push = 0;
    chk("R6 ovf after push at full", int'(tx_ovf), 1);
    chk("R6 fill unchanged", int'(tx_fill), 256);
    flag_clr = 3'b001; tick();
    chk("R9 clear tx_ovf", int'(tx_ovf), 0);
    tx_push = 1; tick(); tx_push = 0; flag_clr = 3'b000;
    chk("R9 set wins over clear", int'(tx_ovf), 1);
    flag_clr = 3'b001; tick(); flag_clr = 3'b000;

    // drain to level, then a burst overlapping one serial pop
    tx_pop = 1; ticks(64); tx_pop = 0;
    tick();
    chk("R1 req at level 192", int'(tx_req), 1);
    tx_ack = 1; tick(); tx_ack = 0;
    tx_push = 1; ticks(63);
    chk("R3 no re-arm inside burst", int'(tx_req), 0);
    tx_pop = 1; tick(); tx_pop = 0; tx_push = 0;
    chk("R11 pop during burst leaves room", int'(tx_fill), 255);
    tick();
    chk("R3 burst closed, above level", int'(tx_req), 0);

    // enable gate and underflow
    tx_en = 0; tx_pop = 1; ticks(255); tx_pop = 0;
    tick();
    chk("R4 tx disabled at empty", int'(tx_req), 0);
    xfer_active = 0; tx_pop = 1; tick();
    chk("R7 empty pop while inactive", int'(tx_unf), 0);
    xfer_active = 1; tick(); tx_pop = 0;
    chk("R7 empty pop while active", int'(tx_unf), 1);
    chk("R7 fill stays 0", int'(tx_fill), 0);
    flag_clr = 3'b010; tick(); flag_clr = 3'b000;

    // configuration check
    tx_thresh = 200; tx_burst = 56; #1;
    chk("R5 burst fits", int'(cfg_err), 0);
    tx_burst = 57; #1;
    chk("R5 burst too long", int'(cfg_err), 1);
    tx_thresh = 192; tx_burst = 64;

    // receive level is register value plus one
    rx_en = 1; rx_thresh = 3; rx_burst = 2;
    rx_push = 1; ticks(3); rx_push = 0;
    tick();
    chk("R2 no req at register value", int'(rx_req), 0);
    rx_push = 1; tick(); rx_push = 0;
    tick();
    chk("R2 req at value plus one", int'(rx_req), 1);
    rx_ack = 1; tick(); rx_ack = 0;
    chk("R3 rx_req drops after ack", int'(rx_req), 0);
    rx_pop = 1; ticks(2); rx_pop = 0;
    tick();
    chk("R3 rx burst drained", int'(rx_fill), 2);
    chk("R3 rx no req below level", int'(rx_req), 0);
    rx_en = 0; tick();
    chk("R4 rx disabled", int'(rx_req), 0);

    // receive overflow
    rx_push = 1; ticks(300); rx_push = 0;
    chk("R8 rx fill full", int'(rx_fill), 256);
    chk("R8 rx_ovf set", int'(rx_ovf), 1);
    flag_clr = 3'b100; tick(); flag_clr = 3'b000;
    chk("R9 clear rx_ovf", int'(rx_ovf), 0);
    rx_pop = 1; ticks(256); rx_pop = 0;

    // random phases: near empty, balanced, near full
    for (int ph = 0; ph < 6; ph++) begin
      int ptp, ptq, prp, prq;
      case (ph % 3)
        0: begin ptp = 30; ptq = 60; prp = 30; prq = 60; end
        1: begin ptp = 50; ptq = 50; prp = 50; prq = 50; end
        default: begin ptp = 70; ptq = 25; prp = 70; prq = 25; end
      endcase
      tx_thresh = LW'($urandom_range(0, DEPTH));
      rx_thresh = LW'($urandom_range(0, DEPTH));
      tx_burst  = LW'($urandom_range(0, 80));
      rx_burst  = LW'($urandom_range(0, 80));
      for (int c = 0; c < 3000; c++) begin
        tx_push = ($urandom_range(0, 99) < ptp);
        tx_pop  = ($urandom_range(0, 99) < ptq);
        rx_push = ($urandom_range(0, 99) < prp);
        rx_pop  = ($urandom_range(0, 99) < prq);
        tx_ack  = ($urandom_range(0, 99) < 30);
        rx_ack  = ($urandom_range(0, 99) < 30);
        tx_en   = ($urandom_range(0, 99) < 90);
        rx_en   = ($urandom_range(0, 99) < 90);
        xfer_active = ($urandom_range(0, 99) < 80);
        flag_clr = {($urandom_range(0, 99) < 5), ($urandom_range(0, 99) < 5),
                    ($urandom_range(0, 99) < 5)};
        if ($urandom_range(0, 499) == 0) tx_thresh = LW'($urandom_range(0, DEPTH));
        if ($urandom_range(0, 499) == 0) rx_burst = LW'($urandom_range(0, 80));
        tick();
      end
    end
    idle_strobes();
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule